// File: doc/BRIEF.md
# One-Hot Control Sequencer for an Accumulator Processor

This block is the hardwired controller of a small accumulator machine. It holds one hot bit in a chain of step flip-flops. Three fetch steps bring the next instruction word into the instruction register. One decode step follows. A short execute chain for the decoded opcode comes next, and the hot bit then returns to the first fetch step. A decoder that resolves every opcode value picks the branch taken out of the decode step.

In each step the block holds a set of level controls steady for the whole cycle: output enables onto the buses, the input paths into MAR, IR and AC, the ALU function code, the memory direction, the PC mode and the SP mode. It also raises one clock-pulse output for each register that the step loads. Each control is the OR of the step lines that need it. Each pulse is the step line gated with the low half of the clock, so a pulse never overlaps a change of the levels. The opcodes handled are load, store, add, logical AND and halt. Any other opcode value goes straight back to fetch.

Top module: `onehot_ctl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `step_hot` becomes 16'h0001 (only the first fetch step) and every pulse output stays low while `rst_n` is low. After release the sequence starts from the first fetch step.
- R2: Exactly one bit of `step_hot` is set in every cycle. The bit positions are: 0-2 fetch 1-3, 3 decode, 4-6 load steps 1-3, 7-8 store steps 1-2, 9-11 add steps 1-3, 12-14 AND steps 1-3, 15 halt.
- R3: Fetch runs bit 0 → 1 → 2 → 3. Bit 0 drives `oe_pc` and `path_mar` and pulses `clk_mar`. Bit 1 drives `oe_mar` and `oe_mem` with `mem_wr`=0 and pulses `clk_mbr` and `clk_pc`, with `pc_load`=0 meaning increment. Bit 2 drives `oe_mbr` and `path_ir` and pulses `clk_ir`.
- R4: Decode (bit 3) drives `oe_op` and pulses nothing. It branches on `opcode`: 8'h01 load to bit 4, 8'h02 store to bit 7, 8'h03 add to bit 9, 8'h04 AND to bit 12, 8'h00 halt to bit 15.
- R5: Load runs bits 4 → 5 → 6. Bit 4 drives `oe_irad` and `path_mar` and pulses `clk_mar`. Bit 5 drives `oe_mar` and `oe_mem` and pulses `clk_mbr`. Bit 6 drives `oe_mbr` and `path_ac_mbr` and pulses `clk_ac`.
- R6: Store runs bits 7 → 8. Bit 7 drives `oe_irad` and `path_mar` and pulses `clk_mar`. Bit 8 drives `oe_mar` and `oe_ac` with `mem_wr`=1 and pulses `clk_mem`.
- R7: Add runs bits 9 → 10 → 11. Its first two steps match load steps 1 and 2. Bit 11 drives `oe_mbr` and `path_ac_alu` with `alu_sel`=3'b100 (sum) and pulses `clk_ac`.
- R8: AND runs bits 12 → 13 → 14 like add, except that bit 14 sets `alu_sel`=3'b011 (bitwise AND).
- R9: Any opcode above 8'h04 sends the hot bit from decode straight back to bit 0.
- R10: Halt (bit 15) keeps the hot bit parked until reset, with every level low and no pulse.
- R11: Pulses are high only while `clk` is low. Levels do not change within a cycle. `alu_sel` is 3'b000 (pass) outside the ALU steps. `sp_mode` stays 2'b00 (hold) and `clk_sp` stays low in every step.
- R12: The last step of each execute chain (bits 6, 8, 11 and 14) passes the hot bit back to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the low half carries the pulses |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| step_hot | output | 16 | One-hot step vector |
| oe_pc | output | 1 | PC onto address path |
| oe_irad | output | 1 | IR address field onto address path |
| oe_op | output | 1 | IR opcode field to the decoder |
| oe_mar | output | 1 | MAR onto the address bus |
| oe_mbr | output | 1 | MBR output enable |
| oe_ac | output | 1 | AC onto the data bus |
| oe_mem | output | 1 | Memory onto the data bus |
| path_mar | output | 1 | Input path into MAR |
| path_ir | output | 1 | Input path into IR |
| path_ac_mbr | output | 1 | MBR-to-AC path |
| path_ac_alu | output | 1 | ALU-to-AC path |
| mem_wr | output | 1 | Memory direction, 1 write, 0 read |
| pc_load | output | 1 | PC mode, 1 load, 0 increment |
| sp_mode | output | 2 | SP mode: 00 hold, 01 load, 10 inc, 11 dec |
| alu_sel | output | 3 | ALU function code |
| clk_mar | output | 1 | MAR clock pulse |
| clk_mbr | output | 1 | MBR clock pulse |
| clk_ir | output | 1 | IR clock pulse |
| clk_pc | output | 1 | PC clock pulse |
| clk_ac | output | 1 | AC clock pulse |
| clk_mem | output | 1 | Memory write pulse |
| clk_sp | output | 1 | SP clock pulse |

## Verification
The second fetch step is the one place where two register loads fall in the same low half-cycle: the MBR capture and the PC increment. Every fetch of the 256-opcode sweep provokes it. The bench compares the whole pulse vector at that moment, so both loads must appear and no other may. The return from an execute chain into fetch also coincides with the bench presenting the next opcode. It is judged by checking that the step vector lands on fetch step 1 and that the new opcode only steers the following decode.

// File: rtl/onehot_ctl_pkg.sv
// Shared step numbering, opcode codes and control word layout for the
// one-hot sequencer. Assumes one hot step at a time.
package onehot_ctl_pkg;
    localparam int NSTEP     = 16;
    localparam int ST_FETCH1 = 0;
    localparam int ST_FETCH2 = 1;
    localparam int ST_FETCH3 = 2;
    localparam int ST_DECODE = 3;
    localparam int ST_LD1    = 4;
    localparam int ST_LD2    = 5;
    localparam int ST_LD3    = 6;
    localparam int ST_ST1    = 7;
    localparam int ST_ST2    = 8;
    localparam int ST_AD1    = 9;
    localparam int ST_AD2    = 10;
    localparam int ST_AD3    = 11;
    localparam int ST_AN1    = 12;
    localparam int ST_AN2    = 13;
    localparam int ST_AN3    = 14;
    localparam int ST_HALT   = 15;

    // opcode values with an execute chain; all higher values have none
    localparam int OPC_HALT = 0;
    localparam int OPC_LDA  = 1;
    localparam int OPC_STA  = 2;
    localparam int OPC_ADD  = 3;
    localparam int OPC_AND  = 4;
    localparam int NCODE    = 5;

    // branch target lines out of the decoder
    localparam int BR_HALT = 0;
    localparam int BR_LDA  = 1;
    localparam int BR_STA  = 2;
    localparam int BR_ADD  = 3;
    localparam int BR_AND  = 4;
    localparam int BR_NONE = 5;
    localparam int NBR     = 6;

    localparam logic [2:0] ALU_PASS = 3'b000;
    localparam logic [2:0] ALU_AND  = 3'b011;
    localparam logic [2:0] ALU_SUM  = 3'b100;
    localparam logic [1:0] SP_HOLD  = 2'b00;

    typedef struct packed {
        logic       oe_pc;
        logic       oe_irad;
        logic       oe_op;
        logic       oe_mar;
        logic       oe_mbr;
        logic       oe_ac;
        logic       oe_mem;
        logic       path_mar;
        logic       path_ir;
        logic       path_ac_mbr;
        logic       path_ac_alu;
        logic       mem_wr;
        logic       pc_load;
        logic [1:0] sp_mode;
        logic [2:0] alu_sel;
    } lvl_t;

    typedef struct packed {
        logic mar;
        logic mbr;
        logic ir;
        logic pc;
        logic ac;
        logic mem;
        logic sp;
    } pls_t;

    typedef struct packed {
        lvl_t lvl;
        pls_t pls;
    } word_t;

    // Control word contributed by one step when it is hot.
    function automatic word_t step_word(input int s);
        word_t w;
        w = '0;
        w.lvl.sp_mode = SP_HOLD;
        w.lvl.alu_sel = ALU_PASS;
        case (s)
            ST_FETCH1: begin
                w.lvl.oe_pc = 1'b1; w.lvl.path_mar = 1'b1; w.pls.mar = 1'b1;
            end
            ST_LD1, ST_ST1, ST_AD1, ST_AN1: begin
                w.lvl.oe_irad = 1'b1; w.lvl.path_mar = 1'b1; w.pls.mar = 1'b1;
            end
            ST_FETCH2: begin
                w.lvl.oe_mar = 1'b1; w.lvl.oe_mem = 1'b1;
                w.pls.mbr = 1'b1; w.pls.pc = 1'b1;
            end
            ST_LD2, ST_AD2, ST_AN2: begin
                w.lvl.oe_mar = 1'b1; w.lvl.oe_mem = 1'b1; w.pls.mbr = 1'b1;
            end
            ST_FETCH3: begin
                w.lvl.oe_mbr = 1'b1; w.lvl.path_ir = 1'b1; w.pls.ir = 1'b1;
            end
            ST_DECODE: w.lvl.oe_op = 1'b1;
            ST_LD3: begin
                w.lvl.oe_mbr = 1'b1; w.lvl.path_ac_mbr = 1'b1; w.pls.ac = 1'b1;
            end
            ST_ST2: begin
                w.lvl.oe_mar = 1'b1; w.lvl.oe_ac = 1'b1;
                w.lvl.mem_wr = 1'b1; w.pls.mem = 1'b1;
            end
            ST_AD3: begin
                w.lvl.oe_mbr = 1'b1; w.lvl.path_ac_alu = 1'b1;
                w.lvl.alu_sel = ALU_SUM; w.pls.ac = 1'b1;
            end
            ST_AN3: begin
                w.lvl.oe_mbr = 1'b1; w.lvl.path_ac_alu = 1'b1;
                w.lvl.alu_sel = ALU_AND; w.pls.ac = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/onehot_ctl_opdec.sv
// Full-width opcode decoder: one line per opcode value, folded into the
// branch targets of the decode step. Assumes OP_W is at least 3.
module onehot_ctl_opdec
    import onehot_ctl_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output logic [NBR-1:0]  tgt
);
    localparam int NOPS = 1 << OP_W;

    logic [NOPS-1:0] sel;

    // one compare per opcode value
    for (genvar g = 0; g < NOPS; g++) begin : g_line
        assign sel[g] = (opcode == OP_W'(g));
    end

    // fold the lines into the branch targets
    always_comb begin
        tgt          = '0;
        tgt[BR_HALT] = sel[OPC_HALT];
        tgt[BR_LDA]  = sel[OPC_LDA];
        tgt[BR_STA]  = sel[OPC_STA];
        tgt[BR_ADD]  = sel[OPC_ADD];
        tgt[BR_AND]  = sel[OPC_AND];
        tgt[BR_NONE] = |sel[NOPS-1:NCODE];
    end
endmodule

// File: rtl/onehot_ctl_ring.sv
// One-hot step register and its next-step network. Assumes tgt is one-hot
// and that the decoder output is valid while the decode step is hot.
module onehot_ctl_ring
    import onehot_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBR-1:0]   tgt,
    output logic [NSTEP-1:0] step_q
);
    logic [NSTEP-1:0] nxt;
    logic             back_to_fetch;

    // next-step network: each step feeds its successor
    always_comb begin
        back_to_fetch  = (step_q[ST_DECODE] & tgt[BR_NONE]) | step_q[ST_LD3]
                       | step_q[ST_ST2] | step_q[ST_AD3] | step_q[ST_AN3];
        nxt            = '0;
        nxt[ST_FETCH1] = back_to_fetch;
        nxt[ST_FETCH2] = step_q[ST_FETCH1];
        nxt[ST_FETCH3] = step_q[ST_FETCH2];
        nxt[ST_DECODE] = step_q[ST_FETCH3];
        nxt[ST_LD1]    = step_q[ST_DECODE] & tgt[BR_LDA];
        nxt[ST_LD2]    = step_q[ST_LD1];
        nxt[ST_LD3]    = step_q[ST_LD2];
        nxt[ST_ST1]    = step_q[ST_DECODE] & tgt[BR_STA];
        nxt[ST_ST2]    = step_q[ST_ST1];
        nxt[ST_AD1]    = step_q[ST_DECODE] & tgt[BR_ADD];
        nxt[ST_AD2]    = step_q[ST_AD1];
        nxt[ST_AD3]    = step_q[ST_AD2];
        nxt[ST_AN1]    = step_q[ST_DECODE] & tgt[BR_AND];
        nxt[ST_AN2]    = step_q[ST_AN1];
        nxt[ST_AN3]    = step_q[ST_AN2];
        nxt[ST_HALT]   = step_q[ST_HALT] | (step_q[ST_DECODE] & tgt[BR_HALT]);
    end

    // step register, reset places the hot bit on the first fetch step
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= NSTEP'(1);
        else        step_q <= nxt;
    end
endmodule

// File: rtl/onehot_ctl_outmap.sv
// Maps the hot step to its control word by ORing the words of all hot steps.
// Assumes step_q is one-hot, so no two words overlap.
module onehot_ctl_outmap
    import onehot_ctl_pkg::*;
(
    input  logic [NSTEP-1:0] step_q,
    output lvl_t             lvl,
    output pls_t             pls_req
);
    word_t each [NSTEP];
    word_t acc;

    // per-step contribution, zero unless the step is hot
    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        assign each[g] = step_q[g] ? step_word(g) : '0;
    end

    // OR of all step contributions
    always_comb begin
        acc = '0;
        for (int i = 0; i < NSTEP; i++) acc = acc | each[i];
    end

    assign lvl     = acc.lvl;
    assign pls_req = acc.pls;
endmodule

// File: rtl/onehot_ctl_pulse.sv
// Gates the pulse requests with the low clock phase and with reset released.
// Assumes the step register changes on the rising edge only.
module onehot_ctl_pulse
    import onehot_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pls_t req,
    output pls_t pls
);
    localparam int NPLS = $bits(pls_t);

    logic phase_ok;

    // pulse window: low half of the cycle, outside reset
    assign phase_ok = ~clk & rst_n;
    assign pls      = req & {NPLS{phase_ok}};
endmodule

// File: rtl/onehot_ctl.sv
// One-hot control sequencer top: decoder, step register, control map and
// pulse gating. Assumes opcode is stable around the end of the decode step.
module onehot_ctl
    import onehot_ctl_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    output logic [NSTEP-1:0] step_hot,
    output logic             oe_pc,
    output logic             oe_irad,
    output logic             oe_op,
    output logic             oe_mar,
    output logic             oe_mbr,
    output logic             oe_ac,
    output logic             oe_mem,
    output logic             path_mar,
    output logic             path_ir,
    output logic             path_ac_mbr,
    output logic             path_ac_alu,
    output logic             mem_wr,
    output logic             pc_load,
    output logic [1:0]       sp_mode,
    output logic [2:0]       alu_sel,
    output logic             clk_mar,
    output logic             clk_mbr,
    output logic             clk_ir,
    output logic             clk_pc,
    output logic             clk_ac,
    output logic             clk_mem,
    output logic             clk_sp
);
    logic [NBR-1:0] tgt;
    lvl_t           lvl;
    pls_t           req;
    pls_t           pls;

    onehot_ctl_opdec #(.OP_W(OP_W)) u_opdec (
        .opcode (opcode),
        .tgt    (tgt)
    );

    onehot_ctl_ring u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgt    (tgt),
        .step_q (step_hot)
    );

    onehot_ctl_outmap u_outmap (
        .step_q  (step_hot),
        .lvl     (lvl),
        .pls_req (req)
    );

    onehot_ctl_pulse u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .pls   (pls)
    );

    // level outputs
    assign oe_pc       = lvl.oe_pc;
    assign oe_irad     = lvl.oe_irad;
    assign oe_op       = lvl.oe_op;
    assign oe_mar      = lvl.oe_mar;
    assign oe_mbr      = lvl.oe_mbr;
    assign oe_ac       = lvl.oe_ac;
    assign oe_mem      = lvl.oe_mem;
    assign path_mar    = lvl.path_mar;
    assign path_ir     = lvl.path_ir;
    assign path_ac_mbr = lvl.path_ac_mbr;
    assign path_ac_alu = lvl.path_ac_alu;
    assign mem_wr      = lvl.mem_wr;
    assign pc_load     = lvl.pc_load;
    assign sp_mode     = lvl.sp_mode;
    assign alu_sel     = lvl.alu_sel;

    // pulse outputs
    assign clk_mar = pls.mar;
    assign clk_mbr = pls.mbr;
    assign clk_ir  = pls.ir;
    assign clk_pc  = pls.pc;
    assign clk_ac  = pls.ac;
    assign clk_mem = pls.mem;
    assign clk_sp  = pls.sp;
endmodule

// File: rtl/onehot_ctl_chk.sv
// Assertion checker for the sequencer, attached to the top by bind.
module onehot_ctl_chk
    import onehot_ctl_pkg::*;
#(
    parameter int OP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  opcode,
    input logic [NSTEP-1:0] step_hot
);
    logic seen_q   = 1'b0;
    logic prev_rst = 1'b1;

    // history of reset for the post-reset state check
    always_ff @(posedge clk) begin
        seen_q   <= 1'b1;
        prev_rst <= rst_n;
        // R1
        if (seen_q && !prev_rst) begin
            reset_state_chk: assert (step_hot == NSTEP'(1))
                else $error("reset did not park on fetch step 1");
        end
    end

    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_hot) == 1);

    // R3
    fetch_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_hot[ST_FETCH1] |=> step_hot[ST_FETCH2]);

    // R3
    fetch_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_hot[ST_FETCH2] |=> step_hot[ST_FETCH3]);

    // R3
    fetch_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_hot[ST_FETCH3] |=> step_hot[ST_DECODE]);

    // R4
    branch_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hot[ST_DECODE] && opcode == OP_W'(OPC_LDA)) |=> step_hot[ST_LD1]);

    // R4
    branch_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hot[ST_DECODE] && opcode == OP_W'(OPC_STA)) |=> step_hot[ST_ST1]);

    // R9
    no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hot[ST_DECODE] && opcode >= OP_W'(NCODE)) |=> step_hot[ST_FETCH1]);

    // R10
    halt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_hot[ST_HALT] |=> step_hot[ST_HALT]);

    // R12
    chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hot[ST_LD3] || step_hot[ST_ST2] || step_hot[ST_AD3] || step_hot[ST_AN3])
        |=> step_hot[ST_FETCH1]);
endmodule

bind onehot_ctl onehot_ctl_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .step_hot (step_hot)
);

// File: tb/onehot_ctl_bench.sv
module onehot_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OPW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OPW-1:0] opcode = '0;
    logic [15:0] step_hot;
    logic oe_pc, oe_irad, oe_op, oe_mar, oe_mbr, oe_ac, oe_mem;
    logic path_mar, path_ir, path_ac_mbr, path_ac_alu, mem_wr, pc_load;
    logic [1:0] sp_mode;
    logic [2:0] alu_sel;
    logic clk_mar, clk_mbr, clk_ir, clk_pc, clk_ac, clk_mem, clk_sp;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    onehot_ctl #(.OP_W(OPW)) u_onehot_ctl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .step_hot(step_hot),
        .oe_pc(oe_pc), .oe_irad(oe_irad), .oe_op(oe_op), .oe_mar(oe_mar),
        .oe_mbr(oe_mbr), .oe_ac(oe_ac), .oe_mem(oe_mem), .path_mar(path_mar),
        .path_ir(path_ir), .path_ac_mbr(path_ac_mbr), .path_ac_alu(path_ac_alu),
        .mem_wr(mem_wr), .pc_load(pc_load), .sp_mode(sp_mode), .alu_sel(alu_sel),
        .clk_mar(clk_mar), .clk_mbr(clk_mbr), .clk_ir(clk_ir), .clk_pc(clk_pc),
        .clk_ac(clk_ac), .clk_mem(clk_mem), .clk_sp(clk_sp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // observed vectors in bench order
    wire [17:0] lvl_v = {oe_pc, oe_irad, oe_op, oe_mar, oe_mbr, oe_ac, oe_mem,
                         path_mar, path_ir, path_ac_mbr, path_ac_alu, mem_wr,
                         pc_load, sp_mode, alu_sel};
    wire [6:0]  pls_v = {clk_mar, clk_mbr, clk_ir, clk_pc, clk_ac, clk_mem, clk_sp};

    // level bit positions in lvl_v
    localparam int B_OEPC = 17, B_IRAD = 16, B_OP = 15, B_MAR = 14, B_MBR = 13;
    localparam int B_AC = 12, B_MEM = 11, B_PMAR = 10, B_PIR = 9, B_PACM = 8;
    localparam int B_PACA = 7, B_WR = 6;
    // pulse bit positions in pls_v
    localparam int P_MAR = 6, P_MBR = 5, P_IR = 4, P_PC = 3, P_AC = 2, P_MEM = 1;

    function automatic logic [17:0] exp_lvl(input int s);
        logic [17:0] v = '0;
        case (s)
            0:            begin v[B_OEPC] = 1; v[B_PMAR] = 1; end
            4, 7, 9, 12:  begin v[B_IRAD] = 1; v[B_PMAR] = 1; end
            1, 5, 10, 13: begin v[B_MAR] = 1; v[B_MEM] = 1; end
            2:            begin v[B_MBR] = 1; v[B_PIR] = 1; end
            3:            v[B_OP] = 1;
            6:            begin v[B_MBR] = 1; v[B_PACM] = 1; end
            8:            begin v[B_MAR] = 1; v[B_AC] = 1; v[B_WR] = 1; end
            11:           begin v[B_MBR] = 1; v[B_PACA] = 1; v[2:0] = 3'b100; end
            14:           begin v[B_MBR] = 1; v[B_PACA] = 1; v[2:0] = 3'b011; end
            default:      v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [6:0] exp_pls(input int s);
        logic [6:0] v = '0;
        case (s)
            0, 4, 7, 9, 12: v[P_MAR] = 1;
            1:              begin v[P_MBR] = 1; v[P_PC] = 1; end
            5, 10, 13:      v[P_MBR] = 1;
            2:              v[P_IR] = 1;
            6, 11, 14:      v[P_AC] = 1;
            8:              v[P_MEM] = 1;
            default:        v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // entered at rising edge + 2; checks one step, leaves at next rising edge + 2
    task automatic do_step(input int s, input string tag);
        logic [17:0] lv_hi;
        chk(tag, "step vector (R2)", 32'(step_hot), 32'(1) << s);
        chk(tag, "levels", 32'(lvl_v), 32'(exp_lvl(s)));
        chk("R11", "pulses while clk high", 32'(pls_v), 32'h0);
        lv_hi = lvl_v;
        @(negedge clk); #2;
        chk(tag, "pulses", 32'(pls_v), 32'(exp_pls(s)));
        chk("R11", "levels stable in low half", 32'(lvl_v), 32'(lv_hi));
        @(posedge clk); #2;
    endtask

    task automatic run_instr(input int op, input string first_tag);
        opcode = OPW'(op);
        do_step(0, first_tag);
        do_step(1, "R3");
        do_step(2, "R3");
        do_step(3, "R4");
        case (op)
            1: begin do_step(4, "R5"); do_step(5, "R5"); do_step(6, "R5"); end
            2: begin do_step(7, "R6"); do_step(8, "R6"); end
            3: begin do_step(9, "R7"); do_step(10, "R7"); do_step(11, "R7"); end
            4: begin do_step(12, "R8"); do_step(13, "R8"); do_step(14, "R8"); end
            default: ;
        endcase
    endtask

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "step vector in reset", 32'(step_hot), 32'h1);
        @(negedge clk); #2;
        chk("R1", "pulses in reset", 32'(pls_v), 32'h0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        tag = "R1";
        for (int op = 1; op < 256; op++) begin
            run_instr(op, tag);
            tag = (op > 4) ? "R9" : "R12";
        end
        run_instr(0, tag);
        for (int k = 0; k < 8; k++) do_step(15, "R10");
        rst_n = 1'b0;
        @(negedge clk); #2;
        chk("R1", "pulses while reset held", 32'(pls_v), 32'h0);
        @(posedge clk); #2;
        chk("R1", "step vector after reset from halt", 32'(step_hot), 32'h1);
        rst_n = 1'b1;
        run_instr(2, "R1");
        run_instr(3, "R12");
        do_step(0, "R12");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule